// File: doc/BRIEF.md
# Nine-Bit Serial Display Word Framer

This block sits between a byte source and a serial display controller that has no separate pin telling commands from data. Every incoming byte arrives with a one-bit tag. The block puts that tag in front of the byte to form a 9-bit word. It then shifts the word out most significant bit first on an SPI mode 0 link, using a serial clock that it divides down from the system clock.

A transaction is a run of bytes ending in one marked as last, typically one command followed by up to fifteen parameters. Chip select stays low for the whole run and the words follow one another with no spare bits between them. A 9-bit word therefore seldom ends on an 8-bit boundary. When the last byte has gone out, the block keeps appending command words that carry a configurable padding opcode until the bit total is a whole number of bytes. It then waits half a serial period and releases chip select. That padding lets a byte-oriented host or capture path on the other side see a clean stream.

Top module: `ninebit_spi_framer`

## Requirements
- R1: Each word is 9 bits, sent MSB first: the tag bit is the first bit on the line and the 8 payload bits follow from bit 7 down to bit 0.
- R2: The tag bit on the line equals `in_is_data`: 0 marks a command byte and 1 marks a data byte.
- R3: All words of one transaction, including its padding, are sent inside a single low period of `spi_cs_n`, each bit on one rising edge of `spi_sclk`, with no extra bits between words.
- R4: After the byte marked `in_last`, the block appends (8 − (n mod 8)) mod 8 padding words for a transaction of n bytes, so the total bit count is a multiple of 8. With 8 or 16 bytes it appends none.
- R5: Each padding word is a command word: tag 0 followed by the value of `pad_opcode`. That value must be held steady while `busy` is high.
- R6: `spi_sclk` is low whenever `spi_cs_n` is high, and `spi_mosi` changes only while `spi_sclk` is low. It is stable across every high phase (mode 0).
- R7: Each high phase of `spi_sclk` lasts HALF_DIV clock cycles. The first rising edge comes HALF_DIV cycles after `spi_cs_n` falls.
- R8: `spi_cs_n` rises HALF_DIV cycles after the last falling edge of `spi_sclk` in a transaction.
- R9: `busy` is high exactly while `spi_cs_n` is low. It rises in the cycle chip select falls and drops in the cycle chip select rises.
- R10: A byte is taken only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is high only while idle or between words, and never while `spi_sclk` is high. A byte source may stall between bytes, and chip select then stays low.
- R11: After reset, `spi_cs_n` is 1, `spi_sclk`, `spi_mosi` and `busy` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block takes the offered byte this cycle |
| in_data | input | DATA_W | Payload byte |
| in_is_data | input | 1 | Tag: 1 for data, 0 for command |
| in_last | input | 1 | Byte closes the transaction |
| pad_opcode | input | DATA_W | Opcode placed in padding command words |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Transaction in progress |

## Verification
All serial timing follows from one divider of HALF_DIV cycles. The first rising edge is due HALF_DIV cycles after chip select falls, each high phase lasts HALF_DIV cycles, and chip select rises HALF_DIV cycles after the final falling edge. The monitor samples on the falling system-clock edge, where every output is settled, and counts those cycles directly. A word is rebuilt one bit per rising serial edge and compared with the scoreboard head when its ninth bit arrives. The total word count and the leftover-bit count are checked in the sample where chip select rises. Bursts of 1 to 16 bytes, mixed tags, stalls between bytes and several padding opcodes are driven.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_TAIL  = 2'd3
  } nbf_state_e;

  // width of the host-side lane the stream must realign to
  localparam int LANE_BITS = 8;

endpackage

// File: rtl/nbf_halfbit_timer.sv
// Produces one tick every HALF_DIV cycles while run is high; held at zero otherwise.
module nbf_halfbit_timer #(
  parameter int HALF_DIV = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_DIV - 1);

  logic [TW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nbf_word_shifter.sv
// Holds one word; the MSB is the line bit. Advance moves to the next bit.
module nbf_word_shifter #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              advance,
  output logic              bit_out,
  output logic              on_last
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sreg_q;
  logic [CW-1:0]     idx_q;

  assign bit_out = sreg_q[WORD_W-1];
  assign on_last = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      sreg_q <= load_word;
      idx_q  <= '0;
    end else if (advance) begin
      sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/nbf_align_tracker.sv
// Tracks the transaction bit total modulo the lane width.
module nbf_align_tracker #(
  parameter int WORD_W = 9,
  parameter int LANE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic word_done,
  output logic aligned_after
);
  localparam int AW = (LANE_W > 1) ? $clog2(LANE_W) : 1;
  localparam logic [AW-1:0] STEP = AW'(WORD_W % LANE_W);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_next;

  assign acc_next      = acc_q + STEP;
  assign aligned_after = (acc_next == '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
    end else if (word_done) begin
      acc_q <= acc_next;
    end
  end
endmodule

// File: rtl/ninebit_spi_framer.sv
module ninebit_spi_framer
  import nbf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_is_data,
  input  logic              in_last,
  input  logic [DATA_W-1:0] pad_opcode,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              spi_cs_n,
  output logic              busy
);
  localparam int WORD_W = DATA_W + 1;

  nbf_state_e state_q;
  logic       last_q;
  logic       sclk_q;
  logic       cs_n_q;
  logic       busy_q;

  logic              tick;
  logic              run;
  logic              accept;
  logic              shifting;
  logic              word_done;
  logic              pad_load;
  logic              on_last;
  logic              aligned_after;
  logic              tail_end;
  logic [WORD_W-1:0] load_word;

  assign in_ready  = (state_q == ST_IDLE) || (state_q == ST_WAIT);
  assign accept    = in_ready && in_valid;
  assign run       = (state_q == ST_SHIFT) || (state_q == ST_TAIL);
  assign shifting  = (state_q == ST_SHIFT) && tick && sclk_q;
  assign word_done = shifting && on_last;
  assign pad_load  = word_done && last_q && !aligned_after;
  assign tail_end  = (state_q == ST_TAIL) && tick;
  assign load_word = accept ? {in_is_data, in_data} : {1'b0, pad_opcode};

  nbf_halfbit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  nbf_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept || pad_load),
    .load_word (load_word),
    .advance   (shifting && !on_last),
    .bit_out   (spi_mosi),
    .on_last   (on_last)
  );

  nbf_align_tracker #(.WORD_W(WORD_W), .LANE_W(LANE_BITS)) u_align (
    .clk           (clk),
    .rst           (rst),
    .clear         (tail_end),
    .word_done     (word_done),
    .aligned_after (aligned_after)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      last_q  <= 1'b0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_SHIFT;
            last_q  <= in_last;
            cs_n_q  <= 1'b0;
            busy_q  <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
          end
          if (word_done) begin
            if (!last_q) begin
              state_q <= ST_WAIT;
            end else if (aligned_after) begin
              state_q <= ST_TAIL;
            end
          end
        end
        ST_WAIT: begin
          if (accept) begin
            state_q <= ST_SHIFT;
            last_q  <= in_last;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
            busy_q  <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign spi_sclk = sclk_q;
  assign spi_cs_n = cs_n_q;
  assign busy     = busy_q;
endmodule

// File: rtl/nbf_checker.sv
module nbf_checker (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n,
  input logic busy
);
  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  // R9
  busy_window_chk: assert property (@(posedge clk) disable iff (rst)
    busy != spi_cs_n);

  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> (!spi_sclk && !$past(spi_sclk)));

  // R10
  ready_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !spi_sclk);

  // R3
  sclk_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> !spi_cs_n);
endmodule

bind ninebit_spi_framer nbf_checker u_nbf_checker (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi),
  .spi_cs_n (spi_cs_n),
  .busy     (busy)
);

// File: tb/tb_ninebit_spi_framer.sv
`timescale 1ns/1ps
module tb_ninebit_spi_framer;
  localparam int HALF_DIV = 7;
  localparam int DATA_W   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic in_is_data = 1'b0;
  logic in_last = 1'b0;
  logic [DATA_W-1:0] pad_opcode = 8'hE3;
  logic spi_sclk, spi_mosi, spi_cs_n, busy;

  always #4 clk = ~clk;

  ninebit_spi_framer #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_is_data(in_is_data), .in_last(in_last),
    .pad_opcode(pad_opcode), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [8:0] exp_w[$];
  bit         exp_pad[$];
  int         exp_tx[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // ---------------- driver ----------------
  task automatic send_byte(input bit flag, input logic [7:0] data, input bit last);
    @(negedge clk);
    in_valid   = 1'b1;
    in_data    = data;
    in_is_data = flag;
    in_last    = last;
    exp_w.push_back({flag, data});
    exp_pad.push_back(1'b0);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = ~data;   // junk while not offered (R10)
    in_last  = 1'b0;
  endtask

  // mode 0: command then data; 1: alternating tags; 2: command then data with stalls
  task automatic send_burst(input int n, input logic [7:0] pad, input int seed, input int mode);
    int pads;
    pad_opcode = pad;
    pads = (8 - (n % 8)) % 8;
    for (int i = 0; i < n; i++) begin
      bit flag;
      logic [7:0] d;
      d = 8'(seed * 29 + i * 53 + 17);
      flag = (mode == 1) ? i[0] : (i != 0);
      if (mode == 2) repeat ((i % 4) * 5) @(negedge clk);
      send_byte(flag, d, i == n - 1);
    end
    for (int k = 0; k < pads; k++) begin
      exp_w.push_back({1'b0, pad});
      exp_pad.push_back(1'b1);
    end
    exp_tx.push_back(n + pads);
    do @(negedge clk); while (spi_cs_n !== 1'b1);
    repeat (3) @(negedge clk);
  endtask

  // ---------------- monitor / scoreboard ----------------
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;
  logic [8:0] shreg = '0;
  int nbits = 0, words_tx = 0, hcnt = 0, lowcnt = 0, tail = 0;
  bit first_pending = 0, hi_bad = 0;
  int busy_bad = 0, ready_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (busy !== !spi_cs_n) busy_bad++;
      if (in_ready && spi_sclk) ready_bad++;
      if (spi_cs_n && !in_ready) ready_bad++;
      if (prev_cs && !spi_cs_n) begin
        words_tx = 0; nbits = 0; lowcnt = 0; first_pending = 1; tail = 0;
      end
      if (!spi_cs_n) begin
        if (spi_sclk && !prev_sclk) begin
          if (first_pending) begin
            chk(lowcnt == HALF_DIV, "R7", "first rise delay", lowcnt, HALF_DIV);
            first_pending = 0;
          end
          shreg = {shreg[7:0], spi_mosi};
          nbits++;
          hcnt = 1; hi_bad = 0;
          if (nbits == 9) begin
            nbits = 0;
            words_tx++;
            if (exp_w.size() == 0) begin
              chk(1'b0, "R3", "unexpected word", int'(shreg), 0);
            end else begin
              logic [8:0] ew;
              bit ip;
              ew = exp_w.pop_front();
              ip = exp_pad.pop_front();
              if (ip) chk(shreg == ew, "R5", "padding word", int'(shreg), int'(ew));
              else    chk(shreg == ew, "R1 R2", "tagged word", int'(shreg), int'(ew));
            end
          end
        end else if (spi_sclk && prev_sclk) begin
          hcnt++;
          if (spi_mosi !== prev_mosi) hi_bad = 1;
        end else if (!spi_sclk && prev_sclk) begin
          chk(hcnt == HALF_DIV, "R7", "high phase length", hcnt, HALF_DIV);
          chk(!hi_bad, "R6", "mosi stable while sclk high", int'(hi_bad), 0);
          tail = 1;
        end else begin
          tail++;
          if (first_pending) lowcnt++;
        end
      end else if (!prev_cs) begin
        int et;
        et = (exp_tx.size() != 0) ? exp_tx.pop_front() : -1;
        chk(words_tx == et, "R3 R4", "words in one chip-select window", words_tx, et);
        chk(nbits == 0, "R4", "bits beyond byte boundary", nbits, 0);
        chk(tail == HALF_DIV, "R8", "release delay", tail, HALF_DIV);
        chk(busy_bad == 0, "R9", "busy vs chip select", busy_bad, 0);
        chk(ready_bad == 0, "R10", "in_ready timing", ready_bad, 0);
      end
      if (spi_cs_n && spi_sclk) chk(1'b0, "R6", "sclk high while deselected", 1, 0);
      prev_sclk = spi_sclk;
      prev_mosi = spi_mosi;
      prev_cs   = spi_cs_n;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(spi_cs_n === 1'b1, "R11", "cs_n after reset", int'(spi_cs_n), 1);
    chk(spi_sclk === 1'b0, "R11", "sclk after reset", int'(spi_sclk), 0);
    chk(spi_mosi === 1'b0, "R11", "mosi after reset", int'(spi_mosi), 0);
    chk(busy === 1'b0, "R11", "busy after reset", int'(busy), 0);
    chk(in_ready === 1'b1, "R11", "in_ready after reset", int'(in_ready), 1);

    // R4 bursts of 1 to 16 bytes, alternating padding opcodes (R5)
    for (int n = 1; n <= 16; n++) begin
      send_burst(n, (n % 2 == 1) ? 8'hE3 : 8'h5C, n, 0);
    end
    // R2 mixed tags
    send_burst(5, 8'h00, 40, 1);
    send_burst(11, 8'hFF, 41, 1);
    // R10 stalls between bytes keep chip select low
    send_burst(3, 8'hA5, 42, 2);
    send_burst(9, 8'h3C, 43, 2);
    send_burst(2, 8'hFF, 44, 0);

    repeat (10) @(negedge clk);
    chk(exp_w.size() == 0, "R4", "words left in scoreboard", exp_w.size(), 0);
    chk(exp_tx.size() == 0, "R3", "transactions left", exp_tx.size(), 0);
    chk(busy_bad == 0, "R9", "busy vs chip select overall", busy_bad, 0);
    chk(ready_bad == 0, "R10", "in_ready overall", ready_bad, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule